// File: doc/BRIEF.md
# Six-Bit Function-Coded Integer ALU

This block is the combinational arithmetic and logic unit of a small 32-bit RISC datapath. It takes two operands and a six-bit function code and returns one result word in the same evaluation. The upper two bits of the code select one of four paths: the adder/subtractor, a bitwise Boolean unit, a barrel shifter, or a signed comparator that reuses the subtractor's flags. Only eleven code values are defined. Every other code gives a result of zero.

Operand selection happens upstream, so an instruction with a constant operand uses the same function code as its register form. Loads and stores form their addresses with the add code, so the add path must produce the full wrapping 32-bit sum. Multiply, divide, instruction decoding and any output register are outside this block.

Top module: `alu6_core`

## Requirements
- R1: Code 0x00 gives `a_i + b_i` modulo 2^32, with no trap and no saturation.
- R2: Code 0x01 gives `a_i - b_i` modulo 2^32.
- R3: Code 0x18 gives bitwise AND, code 0x1E gives bitwise OR, and code 0x16 gives bitwise XOR of the two operands.
- R4: Code 0x33 tests equality, code 0x35 tests signed less-than, and code 0x37 tests signed less-than-or-equal. The outcome is placed in bit 0 (1 for true, 0 for false) and bits 31:1 are 0.
- R5: Code 0x20 shifts `a_i` left logically and code 0x21 shifts it right logically. The shift count is `b_i[4:0]`, bits 31:5 of `b_i` have no effect, and vacated bits are filled with 0.
- R6: Code 0x23 shifts `a_i` right arithmetically by `b_i[4:0]`, filling the vacated upper bits with `a_i[31]`.
- R7: Any code other than the eleven listed in R1 to R6 gives a result of 0.
- R8: The block holds no state. The result follows any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits 4:0 give the shift count |
| fn_i | input | 6 | Function code |
| result_o | output | 32 | Result of the selected operation |

## Verification
On every input change, the assertions check the following:
- the subtractor's zero flag matches operand equality;
- the signed less-than bit agrees with a signed comparison of the operands;
- comparison results have zero upper bits;
- arithmetic right shifts carry the sign into bit 31;
- unlisted codes give zero.

Only the bench's scenarios can show the following:
- exact sums and differences at wrap-around;
- the Boolean truth tables;
- shift counts of 0 and 31;
- that the upper count bits are ignored;
- that the output settles with no clock, because these checks need full expected words computed independently.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

    localparam int FN_W = 6;

    localparam logic [FN_W-1:0] FN_ADD = 6'h00;
    localparam logic [FN_W-1:0] FN_SUB = 6'h01;
    localparam logic [FN_W-1:0] FN_AND = 6'h18;
    localparam logic [FN_W-1:0] FN_OR  = 6'h1E;
    localparam logic [FN_W-1:0] FN_XOR = 6'h16;
    localparam logic [FN_W-1:0] FN_SHL = 6'h20;
    localparam logic [FN_W-1:0] FN_SHR = 6'h21;
    localparam logic [FN_W-1:0] FN_SRA = 6'h23;
    localparam logic [FN_W-1:0] FN_CEQ = 6'h33;
    localparam logic [FN_W-1:0] FN_CLT = 6'h35;
    localparam logic [FN_W-1:0] FN_CLE = 6'h37;

    // Upper two code bits choose the datapath.
    typedef enum logic [1:0] {
        PATH_ARITH = 2'b00,
        PATH_BOOL  = 2'b01,
        PATH_SHIFT = 2'b10,
        PATH_CMP   = 2'b11
    } path_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic zero;
    } flags_t;

    typedef struct packed {
        path_e path;
        logic  listed;
        logic  sub;
        logic  right;
        logic  arith;
    } dec_t;

    function automatic logic fn_listed(input logic [FN_W-1:0] fn);
        case (fn)
            FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR,
            FN_SHL, FN_SHR, FN_SRA, FN_CEQ, FN_CLT, FN_CLE: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu6_addsub.sv
module alu6_addsub
    import alu6_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output flags_t       flags
);

    logic [W-1:0] b_eff_d;

    always_comb begin
        b_eff_d     = sub ? ~b : b;
        sum         = a + b_eff_d + {{(W-1){1'b0}}, sub};
        flags.neg   = sum[W-1];
        flags.ovf   = (a[W-1] == b_eff_d[W-1]) && (sum[W-1] != a[W-1]);
        flags.zero  = (sum == '0);
    end

    // Zero flag of a subtraction must mean the operands are equal (R4).
    always_comb begin
        if (!$isunknown({a, b, sub}) && sub) begin
            p_zero_means_equal_r4: assert (flags.zero == (a == b))
                else $error("zero flag disagrees with operand equality");
        end
    end

    // Subtraction can only overflow when operand signs differ (R2).
    always_comb begin
        if (!$isunknown({a, b, sub}) && sub && flags.ovf) begin
            p_sub_ovf_signs_r2: assert (a[W-1] != b[W-1])
                else $error("subtract overflow with equal signs");
        end
    end

endmodule

// File: rtl/alu6_bool.sv
module alu6_bool #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   tt,
    output logic [W-1:0] y
);

    // Each result bit looks up the truth table at index {a,b}.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = tt[{a[i], b[i]}];
    end

    // An AND table must never set a bit that a is missing (R3).
    always_comb begin
        if (!$isunknown({a, b, tt}) && tt == 4'b1000) begin
            p_and_subset_r3: assert ((y & ~a) == '0)
                else $error("AND result outside operand a");
        end
    end

endmodule

// File: rtl/alu6_shift.sv
module alu6_shift #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  logic           right,
    input  logic           arith,
    output logic [W-1:0]   y
);

    logic           fill_d;
    logic [W-1:0]   src_d;
    logic [W-1:0]   stg [SHW+1];
    logic [W-1:0]   out_d;

    // Left shifts run through the same right shifter on a bit-reversed word.
    always_comb begin
        fill_d = right & arith & a[W-1];
        for (int i = 0; i < W; i++) begin
            src_d[i] = right ? a[i] : a[W-1-i];
        end
    end

    assign stg[0] = src_d;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = amt[k] ? {{STEP{fill_d}}, stg[k][W-1:STEP]} : stg[k];
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out_d[i] = right ? stg[SHW][i] : stg[SHW][W-1-i];
        end
    end

    assign y = out_d;

    // Arithmetic right shift keeps the sign in the top bit (R6).
    always_comb begin
        if (!$isunknown({a, amt, right, arith}) && right && arith) begin
            p_sra_sign_fill_r6: assert (y[W-1] == a[W-1])
                else $error("arithmetic shift lost the sign");
        end
    end

    // Nonzero left shift clears bit 0 (R5).
    always_comb begin
        if (!$isunknown({a, amt, right}) && !right && amt != '0) begin
            p_shl_low_clear_r5: assert (y[0] == 1'b0)
                else $error("left shift left bit 0 set");
        end
    end

endmodule

// File: rtl/alu6_compare.sv
module alu6_compare
    import alu6_pkg::*;
#(
    parameter int W = 32
) (
    input  flags_t       flags,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);

    logic lt_d;
    logic hit_d;

    always_comb begin
        lt_d = flags.neg ^ flags.ovf;
        case (sel)
            2'b01:   hit_d = flags.zero;
            2'b10:   hit_d = lt_d;
            2'b11:   hit_d = lt_d | flags.zero;
            default: hit_d = 1'b0;
        endcase
        y = {{(W-1){1'b0}}, hit_d};
    end

endmodule

// File: rtl/alu6_core.sv
module alu6_core
    import alu6_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [FN_W-1:0] fn_i,
    output logic [W-1:0]    result_o
);

    dec_t         dec_d;
    logic [W-1:0] arith_y;
    logic [W-1:0] bool_y;
    logic [W-1:0] shift_y;
    logic [W-1:0] cmp_y;
    flags_t       flags;
    logic [W-1:0] res_d;

    // Decode: code fields drive the path controls directly.
    always_comb begin
        dec_d.path   = path_e'(fn_i[5:4]);
        dec_d.listed = fn_listed(fn_i);
        dec_d.sub    = fn_i[0];
        dec_d.right  = fn_i[0];
        dec_d.arith  = fn_i[1];
    end

    alu6_addsub #(.W(W)) u_addsub (
        .a     (a_i),
        .b     (b_i),
        .sub   (dec_d.sub),
        .sum   (arith_y),
        .flags (flags)
    );

    alu6_bool #(.W(W)) u_bool (
        .a  (a_i),
        .b  (b_i),
        .tt (fn_i[3:0]),
        .y  (bool_y)
    );

    alu6_shift #(.W(W)) u_shift (
        .a     (a_i),
        .amt   (b_i[SHW-1:0]),
        .right (dec_d.right),
        .arith (dec_d.arith),
        .y     (shift_y)
    );

    alu6_compare #(.W(W)) u_cmp (
        .flags (flags),
        .sel   (fn_i[2:1]),
        .y     (cmp_y)
    );

    always_comb begin
        res_d = '0;
        if (dec_d.listed) begin
            case (dec_d.path)
                PATH_ARITH: res_d = arith_y;
                PATH_BOOL:  res_d = bool_y;
                PATH_SHIFT: res_d = shift_y;
                PATH_CMP:   res_d = cmp_y;
                default:    res_d = '0;
            endcase
        end
    end

    assign result_o = res_d;

    // Unlisted codes yield zero (R7).
    always_comb begin
        if (!$isunknown({a_i, b_i, fn_i}) && !fn_listed(fn_i)) begin
            p_unlisted_zero_r7: assert (result_o == '0)
                else $error("unlisted code gave nonzero result");
        end
    end

    // Comparison results occupy bit 0 only (R4).
    always_comb begin
        if (!$isunknown({a_i, b_i, fn_i}) && fn_i[5:4] == 2'b11) begin
            p_cmp_upper_zero_r4: assert (result_o[W-1:1] == '0)
                else $error("comparison set upper bits");
        end
    end

    // Signed less-than built from flags matches a signed compare (R4).
    always_comb begin
        if (!$isunknown({a_i, b_i, fn_i}) && fn_i == FN_CLT) begin
            p_lt_signed_r4: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
                else $error("signed less-than mismatch");
        end
    end

endmodule

// File: tb/alu6_core_test.sv
`timescale 1ns/1ps
module alu6_core_test;

    logic        clk = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [5:0]  fn_i = '0;
    logic [31:0] result_o;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    alu6_core uut (
        .a_i      (a_i),
        .b_i      (b_i),
        .fn_i     (fn_i),
        .result_o (result_o)
    );

    localparam logic [5:0] CODES [11] = '{6'h00, 6'h01, 6'h18, 6'h1E, 6'h16,
                                          6'h20, 6'h21, 6'h23, 6'h33, 6'h35, 6'h37};
    localparam logic [31:0] EDGES [8] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000,
                                          32'h7FFF_FFFF, 32'h1, 32'h1F, 32'hFFFF_FFE0, 32'h5A5A_A5A5};

    function automatic logic [31:0] model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h00: return a + b;
            6'h01: return a - b;
            6'h18: return a & b;
            6'h1E: return a | b;
            6'h16: return a ^ b;
            6'h20: return a << b[4:0];
            6'h21: return a >> b[4:0];
            6'h23: return $unsigned($signed(a) >>> b[4:0]);
            6'h33: return {31'b0, a == b};
            6'h35: return {31'b0, $signed(a) < $signed(b)};
            6'h37: return {31'b0, $signed(a) <= $signed(b)};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s fn=%h a=%h b=%h got=%h exp=%h", req, fn_i, a_i, b_i, got, exp);
        end
    endtask

    task automatic apply(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        fn_i <= fn; a_i <= a; b_i <= b;
        @(negedge clk);
    endtask

    task automatic t_idle;
        apply(6'h00, 32'h0, 32'h0);
        check("R1 idle", result_o, 32'h0);
    endtask

    task automatic t_arith;
        apply(6'h00, 32'hFFFF_FFFF, 32'h1);           check("R1 wrap", result_o, 32'h0);
        apply(6'h00, 32'h7FFF_FFFF, 32'h1);           check("R1 maxpos", result_o, 32'h8000_0000);
        apply(6'h00, 32'h1234_5678, 32'h1111_1111);   check("R1 plain", result_o, 32'h2345_6789);
        apply(6'h01, 32'h0, 32'h1);                   check("R2 wrap", result_o, 32'hFFFF_FFFF);
        apply(6'h01, 32'h8000_0000, 32'h1);           check("R2 minneg", result_o, 32'h7FFF_FFFF);
    endtask

    task automatic t_bool;
        apply(6'h18, 32'hF0F0_FF00, 32'hFF00_0FF0);   check("R3 and", result_o, 32'hF000_0F00);
        apply(6'h1E, 32'hF0F0_FF00, 32'hFF00_0FF0);   check("R3 or", result_o, 32'hFFF0_FFF0);
        apply(6'h16, 32'hF0F0_FF00, 32'hFF00_0FF0);   check("R3 xor", result_o, 32'h0FF0_F0F0);
    endtask

    task automatic t_compare;
        apply(6'h33, 32'h8000_0000, 32'h8000_0000);   check("R4 eq", result_o, 32'h1);
        apply(6'h35, 32'h8000_0000, 32'h7FFF_FFFF);   check("R4 lt ovf", result_o, 32'h1);
        apply(6'h35, 32'h7FFF_FFFF, 32'h8000_0000);   check("R4 lt false", result_o, 32'h0);
        apply(6'h37, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   check("R4 le equal", result_o, 32'h1);
        apply(6'h37, 32'h0, 32'hFFFF_FFFF);           check("R4 le false", result_o, 32'h0);
    endtask

    task automatic t_shift;
        apply(6'h20, 32'h8000_0001, 32'h0);           check("R5 shl 0", result_o, 32'h8000_0001);
        apply(6'h20, 32'h0000_0003, 32'h1F);          check("R5 shl 31", result_o, 32'h8000_0000);
        apply(6'h21, 32'h8000_0000, 32'h1F);          check("R5 shr 31", result_o, 32'h1);
        apply(6'h21, 32'hF000_0000, 32'hFFFF_FFE4);   check("R5 upper count ignored", result_o, 32'h0F00_0000);
    endtask

    task automatic t_sra;
        apply(6'h23, 32'h8000_0000, 32'h1F);          check("R6 sra 31 neg", result_o, 32'hFFFF_FFFF);
        apply(6'h23, 32'h7FFF_FFFF, 32'h1F);          check("R6 sra 31 pos", result_o, 32'h0);
        apply(6'h23, 32'hF000_0000, 32'h4);           check("R6 sra 4", result_o, 32'hFF00_0000);
    endtask

    task automatic t_unlisted;
        for (int c = 0; c < 64; c++) begin
            apply(6'(c), 32'hDEAD_BEEF, 32'h1234_5673);
            check("R7 code sweep", result_o, model(6'(c), 32'hDEAD_BEEF, 32'h1234_5673));
        end
    endtask

    task automatic t_no_clock;
        @(negedge clk);
        fn_i = 6'h00; a_i = 32'h10; b_i = 32'h20;
        #1 check("R8 settle add", result_o, 32'h30);
        fn_i = 6'h1E;
        #1 check("R8 settle or", result_o, 32'h30);
    endtask

    task automatic t_edges;
        for (int ci = 0; ci < 11; ci++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    apply(CODES[ci], EDGES[i], EDGES[j]);
                    check("R1-R6 edge", result_o, model(CODES[ci], EDGES[i], EDGES[j]));
                end
    endtask

    task automatic t_random;
        for (int n = 0; n < 2000; n++) begin
            automatic logic [5:0]  fn = CODES[$urandom_range(0, 10)];
            automatic logic [31:0] a  = $urandom;
            automatic logic [31:0] b  = $urandom;
            apply(fn, a, b);
            check("random", result_o, model(fn, a, b));
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_idle();
        t_arith();
        t_bool();
        t_compare();
        t_shift();
        t_sra();
        t_unlisted();
        t_no_clock();
        t_edges();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule